// File: doc/BRIEF.md
# Packed Unsigned Widening Unit

This block is a SIMD execution stage that widens packed unsigned integers. One instruction takes narrow elements from the low end of a 256-bit source operand. It zero-extends each element into a wider destination element, keeping element order, and delivers a 256-bit result one clock later. There are six widening modes, and each mode has a fixed widening ratio of two, four or eight. The source operand arrives already padded. The previous value of the destination register comes in alongside it, because some encodings keep part of it.

Three encoding forms decide what happens to the upper half of the destination:

- The legacy 128-bit form keeps the old upper half.
- The short vector form clears the upper half.
- The wide vector form builds the upper half from the next source chunk.

In both vector forms a reserved 4-bit register field must be all ones. A bad field, an unused mode code, the reserved form code, or a wide request on a build without wide support raises the undefined-opcode flag. A faulting instruction drops its write-enable and passes the old destination through unchanged.

Top module: `zx_unit`

## Requirements
- R1: `op_sel` picks the mode: 0 byte→word, 1 byte→dword, 2 byte→qword, 3 word→dword, 4 word→qword, 5 dword→qword. Source element i goes to destination element i in ascending order, and all bits above the source width are zero.
- R2: The low 128 result bits use only the low 8 source bytes for ×2 modes (0, 3, 5), the low 4 bytes for ×4 modes (1, 4) and the low 2 bytes for the ×8 mode (2). In the two 128-bit forms no other source byte changes the result.
- R3: With `form` = 0 (legacy 128-bit), result[255:128] equals the old destination's bits 255:128.
- R4: With `form` = 1 (vector 128-bit), result[255:128] is zero.
- R5: With `form` = 2 (vector 256-bit), result[255:128] is built like the low half, but from the next contiguous source chunk of the same size. That chunk is 8, 4 or 2 bytes, starting right after the chunk the low half used.
- R6: In forms 1 and 2, `xreg` other than 4'b1111 raises the fault. In form 0, `xreg` has no effect.
- R7: `op_sel` 6 or 7, or `form` = 3, raises the fault.
- R8: On a fault, `ud_fault` is 1, `wr_en` is 0, and `result` equals the old destination value.
- R9: With parameter `WIDE_EN` = 0, form 2 raises the fault. Form 1 still operates normally.
- R10: Outputs are registered with one cycle of latency. `out_valid` follows `in_valid` by one cycle. Without `in_valid`, the three strobes go low and `result` holds its last value.
- R11: A synchronous active-high reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| src | input | 256 | Padded source operand |
| dst_old | input | 256 | Previous destination register value |
| op_sel | input | 3 | Widening mode select |
| form | input | 2 | Encoding form: 0 legacy 128, 1 vector 128, 2 vector 256, 3 reserved |
| xreg | input | 4 | Reserved register field, must be 4'b1111 in vector forms |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 256 | Widened result or passed-through destination |
| wr_en | output | 1 | Destination write enable |
| ud_fault | output | 1 | Undefined-opcode flag |

## Verification
Every mode is first driven with a source whose bytes count upward from 1. This exposes any misplaced, swapped or reordered element, and a wrong chunk offset in the wide form. An all-ones source then catches sign extension or a missing zero fill. A source whose unused bytes are nonzero shows that the 128-bit forms read no bytes beyond their chunk. Runs with the fault conditions, and on a second instance built without wide support, separate the pass-through path from the widening path.

// File: rtl/zx_pkg.sv
package zx_pkg;

    localparam int ZX_LANE_W = 128;
    localparam int ZX_NLANE  = 2;
    localparam int ZX_OP_W   = ZX_LANE_W * ZX_NLANE;
    localparam int ZX_NMODES = 6;
    localparam logic [3:0] ZX_XREG_OK = 4'b1111;

    typedef enum logic [1:0] {
        FORM_LEG128 = 2'd0,
        FORM_VEC128 = 2'd1,
        FORM_VEC256 = 2'd2,
        FORM_RSVD   = 2'd3
    } form_t;

    typedef enum logic [2:0] {
        W_B2W = 3'd0,
        W_B2D = 3'd1,
        W_B2Q = 3'd2,
        W_W2D = 3'd3,
        W_W2Q = 3'd4,
        W_D2Q = 3'd5
    } widen_t;

    function automatic int src_w(input int m);
        case (m)
            0, 1, 2: return 8;
            3, 4:    return 16;
            default: return 32;
        endcase
    endfunction

    function automatic int dst_w(input int m);
        case (m)
            0:       return 16;
            1, 3:    return 32;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/zx_decode.sv
module zx_decode #(
    parameter bit WIDE_EN = 1'b1
) (
    input  logic [2:0] op_sel,
    input  logic [1:0] form,
    input  logic [3:0] xreg,
    output logic       fault
);
    import zx_pkg::*;

    form_t fm;
    logic  bad_op, bad_form, bad_xreg, bad_wide;

    always_comb begin
        fm       = form_t'(form);
        bad_op   = (int'(op_sel) >= ZX_NMODES);
        bad_form = (fm == FORM_RSVD);
        bad_xreg = (fm == FORM_VEC128 || fm == FORM_VEC256) && (xreg != ZX_XREG_OK);
        bad_wide = (fm == FORM_VEC256) && !WIDE_EN;
        fault    = bad_op | bad_form | bad_xreg | bad_wide;
    end
endmodule

// File: rtl/zx_lane.sv
module zx_lane #(
    parameter int LANE_W   = zx_pkg::ZX_LANE_W,
    parameter int IN_W     = zx_pkg::ZX_OP_W,
    parameter int LANE_IDX = 0
) (
    input  logic [IN_W-1:0]   src,
    input  logic [2:0]        op_sel,
    output logic [LANE_W-1:0] res
);
    import zx_pkg::*;

    logic [LANE_W-1:0] cand [ZX_NMODES];

    for (genvar m = 0; m < ZX_NMODES; m++) begin : g_mode
        localparam int SW = src_w(m);
        localparam int DW = dst_w(m);
        localparam int NE = LANE_W / DW;
        localparam int CH = NE * SW;
        logic [LANE_W-1:0] w;
        for (genvar e = 0; e < NE; e++) begin : g_elem
            assign w[e*DW +: DW] = {{(DW-SW){1'b0}}, src[LANE_IDX*CH + e*SW +: SW]};
        end
        assign cand[m] = w;
    end

    always_comb begin
        res = '0;
        for (int m = 0; m < ZX_NMODES; m++) begin
            if (int'(op_sel) == m) res = cand[m];
        end
    end
endmodule

// File: rtl/zx_unit.sv
module zx_unit #(
    parameter bit WIDE_EN = 1'b1,
    parameter int LANE_W  = zx_pkg::ZX_LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2*LANE_W-1:0] src,
    input  logic [2*LANE_W-1:0] dst_old,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        form,
    input  logic [3:0]        xreg,
    output logic              out_valid,
    output logic [2*LANE_W-1:0] result,
    output logic              wr_en,
    output logic              ud_fault
);
    import zx_pkg::*;

    localparam int OP_W = 2 * LANE_W;

    logic              fault;
    logic [LANE_W-1:0] lo_res, hi_res, upper;
    logic [OP_W-1:0]   next_res;

    zx_decode #(.WIDE_EN(WIDE_EN)) u_dec (
        .op_sel(op_sel), .form(form), .xreg(xreg), .fault(fault)
    );

    zx_lane #(.LANE_W(LANE_W), .IN_W(OP_W), .LANE_IDX(0)) u_lo (
        .src(src), .op_sel(op_sel), .res(lo_res)
    );

    zx_lane #(.LANE_W(LANE_W), .IN_W(OP_W), .LANE_IDX(1)) u_hi (
        .src(src), .op_sel(op_sel), .res(hi_res)
    );

    always_comb begin
        case (form_t'(form))
            FORM_LEG128: upper = dst_old[OP_W-1:LANE_W];
            FORM_VEC256: upper = hi_res;
            default:     upper = '0;
        endcase
        next_res = fault ? dst_old : {upper, lo_res};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            ud_fault  <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid & ~fault;
            ud_fault  <= in_valid & fault;
            if (in_valid) result <= next_res;
        end
    end

    a_r10_strobe: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en && !ud_fault && $stable(result)));
    a_r8_fault_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fault) |=> (ud_fault && !wr_en && result == $past(dst_old)));
    a_r3_keep_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fault && form == FORM_LEG128)
        |=> result[OP_W-1:LANE_W] == $past(dst_old[OP_W-1:LANE_W]));
    a_r4_clear_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fault && form == FORM_VEC128) |=> result[OP_W-1:LANE_W] == '0);
    a_r11_reset: assert property (@(posedge clk)
        rst |=> (!out_valid && !wr_en && !ud_fault && result == '0));
endmodule

// File: tb/tb_zx_unit.sv
module tb_zx_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [255:0] src = '0, dst_old = '0;
    logic [2:0]   op_sel = '0;
    logic [1:0]   form = '0;
    logic [3:0]   xreg = 4'hF;
    logic         out_valid, wr_en, ud_fault;
    logic [255:0] result;
    logic         n_valid, n_wr, n_ud;
    logic [255:0] n_result;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    zx_unit dut (.clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .dst_old(dst_old),
        .op_sel(op_sel), .form(form), .xreg(xreg), .out_valid(out_valid),
        .result(result), .wr_en(wr_en), .ud_fault(ud_fault));

    zx_unit #(.WIDE_EN(1'b0)) dut_narrow (.clk(clk), .rst(rst), .in_valid(in_valid),
        .src(src), .dst_old(dst_old), .op_sel(op_sel), .form(form), .xreg(xreg),
        .out_valid(n_valid), .result(n_result), .wr_en(n_wr), .ud_fault(n_ud));

    function automatic logic [255:0] model(input logic [255:0] s, input logic [255:0] old,
            input logic [2:0] op, input logic [1:0] fm, input logic [3:0] xr,
            input bit wide, output bit flt);
        logic [255:0] r;
        int sw, dw, n;
        flt = (op > 3'd5) || (fm == 2'd3) || (fm != 2'd0 && xr != 4'hF) || (fm == 2'd2 && !wide);
        if (flt) return old;
        case (op)
            3'd0: begin sw = 8;  dw = 16; end
            3'd1: begin sw = 8;  dw = 32; end
            3'd2: begin sw = 8;  dw = 64; end
            3'd3: begin sw = 16; dw = 32; end
            3'd4: begin sw = 16; dw = 64; end
            default: begin sw = 32; dw = 64; end
        endcase
        n = 128 / dw;
        r = '0;
        for (int l = 0; l < 2; l++)
            for (int e = 0; e < n; e++)
                for (int b = 0; b < sw; b++)
                    r[l*128 + e*dw + b] = s[(l*n + e)*sw + b];
        if (fm == 2'd0) r[255:128] = old[255:128];
        else if (fm == 2'd1) r[255:128] = '0;
        return r;
    endfunction

    function automatic logic [255:0] ramp(input int base);
        logic [255:0] v;
        for (int i = 0; i < 32; i++) v[i*8 +: 8] = 8'(base + i);
        return v;
    endfunction

    task automatic chk(input string req, input string what, input logic [255:0] act,
                       input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input string req, input logic [255:0] s, input logic [255:0] old,
                           input logic [2:0] op, input logic [1:0] fm, input logic [3:0] xr);
        bit f, fn;
        logic [255:0] e, en;
        e  = model(s, old, op, fm, xr, 1'b1, f);
        en = model(s, old, op, fm, xr, 1'b0, fn);
        @(negedge clk);
        src = s; dst_old = old; op_sel = op; form = fm; xreg = xr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "result", result, e);
        chk(req, "valid", {255'b0, out_valid}, 256'd1);
        chk(req, "wr_en", {255'b0, wr_en}, {255'b0, !f});
        chk(req, "fault", {255'b0, ud_fault}, {255'b0, f});
        chk(req, "narrow result", n_result, en);
        chk(req, "narrow fault", {255'b0, n_ud}, {255'b0, fn});
    endtask

    task automatic t_reset();
        chk("R11", "valid", {255'b0, out_valid}, '0);
        chk("R11", "wr_en", {255'b0, wr_en}, '0);
        chk("R11", "fault", {255'b0, ud_fault}, '0);
        chk("R11", "result", result, '0);
    endtask

    task automatic t_legacy();
        for (int op = 0; op < 6; op++) begin
            run_one("R1_R3", ramp(1), ramp(8'hA0), 3'(op), 2'd0, 4'hF);
            run_one("R1_R2", {256{1'b1}}, ramp(8'h40), 3'(op), 2'd0, 4'hF);
        end
    endtask

    task automatic t_vec128();
        for (int op = 0; op < 6; op++)
            run_one("R4_R2", ramp(8'h11), {256{1'b1}}, 3'(op), 2'd1, 4'hF);
    endtask

    task automatic t_vec256();
        for (int op = 0; op < 6; op++)
            run_one("R5", ramp(1), ramp(8'h70), 3'(op), 2'd2, 4'hF);
    endtask

    task automatic t_xreg();
        run_one("R6_R8", ramp(3), ramp(8'h55), 3'd0, 2'd1, 4'b0111);
        run_one("R6_R8", ramp(3), ramp(8'h55), 3'd5, 2'd2, 4'b1110);
        run_one("R6", ramp(3), ramp(8'h55), 3'd1, 2'd0, 4'b0000);
    endtask

    task automatic t_illegal();
        run_one("R7", ramp(9), ramp(8'h33), 3'd6, 2'd0, 4'hF);
        run_one("R7", ramp(9), ramp(8'h33), 3'd7, 2'd1, 4'hF);
        run_one("R7", ramp(9), ramp(8'h33), 3'd2, 2'd3, 4'hF);
    endtask

    task automatic t_narrow();
        run_one("R9", ramp(5), ramp(8'h21), 3'd3, 2'd2, 4'hF);
        run_one("R9", ramp(5), ramp(8'h21), 3'd3, 2'd1, 4'hF);
    endtask

    task automatic t_idle();
        logic [255:0] held;
        bit f;
        run_one("R10", ramp(2), ramp(8'h90), 3'd0, 2'd1, 4'hF);
        held = model(ramp(2), ramp(8'h90), 3'd0, 2'd1, 4'hF, 1'b1, f);
        @(negedge clk);
        src = ramp(8'hC0); op_sel = 3'd4;
        @(negedge clk);
        chk("R10", "idle valid", {255'b0, out_valid}, '0);
        chk("R10", "idle wr_en", {255'b0, wr_en}, '0);
        chk("R10", "held result", result, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_legacy();
        t_vec128();
        t_vec256();
        t_xreg();
        t_illegal();
        t_narrow();
        t_idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule